// File: doc/BRIEF.md
# Page-Aligned Write Splitter

This block sits in front of a page-program engine for a serial flash. It accepts a write request with any start address and any byte count, and splits it into a sequence of program requests. No request crosses a page boundary. The first request runs only to the next page boundary. Every middle request covers one whole page. The last request is cut short to the bytes that are left.

Each request carries three values:
- the flash address where the chunk starts;
- the chunk length;
- the offset of the chunk inside the caller's data buffer.

The downstream engine takes care of everything needed to program one chunk: moving the data, enabling writes and waiting while the flash is busy. When it finishes, it returns a single-cycle completion pulse. The splitter issues the next chunk only after that pulse. After the completion of the last chunk, it raises a one-cycle done flag.

The page size is a power-of-two parameter. The position inside a page is taken from the low address bits.

Top module: `page_write_splitter`

## Requirements
- R1: After reset, `busy_o`, `chunk_valid_o` and `done_o` are all low.
- R2: The first chunk has length min(PAGE_BYTES - (start mod PAGE_BYTES), total length).
- R3: No chunk crosses a page boundary: (chunk_addr mod PAGE_BYTES) + chunk_len <= PAGE_BYTES. Every chunk except the last ends exactly on a boundary.
- R4: Every chunk is non-zero. The last chunk is clipped to the remaining byte count, so the chunk lengths add up exactly to the total length.
- R5: Chunks are issued in ascending order. `chunk_offset_o` equals the number of bytes issued before the chunk. `chunk_addr_o` equals (start + offset) mod 2^ADDR_W.
- R6: After a chunk is accepted (`chunk_valid_o` and `chunk_ready_i` both high at a clock edge), `chunk_valid_o` stays low until `chunk_done_i` is sampled high. The next request appears in the cycle after that edge.
- R7: While `chunk_valid_o` is high and `chunk_ready_i` is low, the request stays valid and its address, length and offset do not change.
- R8: `done_o` is high for exactly one cycle, in the cycle after the completion of the last chunk is sampled. In the cycle after that, `busy_o` is low.
- R9: A request with a total length of zero issues no chunk. `done_o` is high in the cycle after `start_i` is sampled.
- R10: `start_i` is ignored while `busy_o` is high. The chunks of the request in progress are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only when idle |
| start_addr_i | input | ADDR_W | Start address of the write |
| total_len_i | input | LEN_W | Total byte count |
| busy_o | output | 1 | A request is in progress |
| chunk_valid_o | output | 1 | Chunk request is valid |
| chunk_ready_i | input | 1 | Engine accepts the chunk request |
| chunk_addr_o | output | ADDR_W | Flash address of the chunk |
| chunk_len_o | output | $clog2(PAGE_BYTES)+1 | Chunk byte count |
| chunk_offset_o | output | LEN_W | Offset of the chunk in the source buffer |
| chunk_done_i | input | 1 | Engine finished the accepted chunk |
| done_o | output | 1 | One-cycle pulse when the whole request completes |

## Verification
The bench uses 8-byte pages and a 6-bit address. It sweeps every start address against every total length from 0 to 19. This set covers:
- requests that fit inside one page;
- requests that end exactly on a boundary;
- requests that start on a boundary;
- requests that span three pages;
- requests that wrap past the top of the address space.

Because all of these are covered, an error in the first-chunk rule, the clipping rule or the offset bookkeeping shows up as a wrong chunk tuple. The zero-length case is also included.

The ready and completion delays vary with the address and the chunk index. This separates correct holding of a stalled request, and correct waiting for completion, from a design that assumes a fixed latency. Spurious start strobes are applied while the engine is busy, to show they leave the chunk sequence unchanged.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } pws_state_e;
endpackage

// File: rtl/pws_chunk_calc.sv
module pws_chunk_calc #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int CLEN_W = PAGE_W + 1
) (
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [LEN_W-1:0]  total_i,
  input  logic [LEN_W-1:0]  written_i,
  output logic [ADDR_W-1:0] chunk_addr_o,
  output logic [CLEN_W-1:0] chunk_len_o,
  output logic              last_o
);
  localparam int CMP_W = (LEN_W > CLEN_W) ? LEN_W : CLEN_W;

  logic [PAGE_W-1:0] page_off;
  logic [CLEN_W-1:0] page_room;
  logic [LEN_W-1:0]  remaining;
  logic [CMP_W-1:0]  room_w, rem_w;

  always_comb begin
    chunk_addr_o = base_addr_i + ADDR_W'(written_i);
    page_off     = chunk_addr_o[PAGE_W-1:0];
    page_room    = CLEN_W'(PAGE_BYTES) - CLEN_W'(page_off);
    remaining    = total_i - written_i;
    room_w       = CMP_W'(page_room);
    rem_w        = CMP_W'(remaining);
    // clip to remaining bytes when they fit inside this page
    last_o       = (rem_w <= room_w);
    chunk_len_o  = last_o ? CLEN_W'(remaining) : page_room;
  end
endmodule

// File: rtl/pws_progress.sv
module pws_progress #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  localparam int CLEN_W = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  total_len_i,
  input  logic [CLEN_W-1:0] chunk_len_i,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [LEN_W-1:0]  total_o,
  output logic [LEN_W-1:0]  written_o,
  output logic              len_zero_o
);
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  total_q, written_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      total_q   <= '0;
      written_q <= '0;
    end else if (load_i) begin
      base_q    <= start_addr_i;
      total_q   <= total_len_i;
      written_q <= '0;
    end else if (advance_i) begin
      written_q <= written_q + LEN_W'(chunk_len_i);
    end
  end

  assign base_addr_o = base_q;
  assign total_o     = total_q;
  assign written_o   = written_q;
  assign len_zero_o  = (total_len_i == '0);

  // R10: request parameters only change on a load
  a_r10_hold_params: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_q) && $stable(total_q));

  // R4: progress never passes the total
  a_r4_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> written_q <= total_q);
endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
  import pws_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic len_zero_i,
  input  logic last_i,
  input  logic chunk_ready_i,
  input  logic chunk_done_i,
  output logic load_o,
  output logic advance_o,
  output logic chunk_valid_o,
  output logic busy_o,
  output logic done_o
);
  pws_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    advance_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = len_zero_i ? ST_FINISH : ST_ISSUE;
      end
      ST_ISSUE: if (chunk_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (chunk_done_i) begin
        advance_o = 1'b1;
        state_d   = last_i ? ST_FINISH : ST_ISSUE;
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign chunk_valid_o = (state_q == ST_ISSUE);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_FINISH);

  // R6: stay waiting until the engine reports completion
  a_r6_wait_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !chunk_done_i) |=> state_q == ST_WAIT);

  // R9: zero-length request goes straight to completion
  a_r9_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && len_zero_i) |=> state_q == ST_FINISH);
endmodule

// File: rtl/page_write_splitter.sv
module page_write_splitter #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int CLEN_W = PAGE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  total_len_i,
  output logic              busy_o,
  output logic              chunk_valid_o,
  input  logic              chunk_ready_i,
  output logic [ADDR_W-1:0] chunk_addr_o,
  output logic [CLEN_W-1:0] chunk_len_o,
  output logic [LEN_W-1:0]  chunk_offset_o,
  input  logic              chunk_done_i,
  output logic              done_o
);
  logic              load, advance, len_zero, last;
  logic [ADDR_W-1:0] base_addr;
  logic [LEN_W-1:0]  total, written;

  pws_progress #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_progress (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .advance_i    (advance),
    .start_addr_i (start_addr_i),
    .total_len_i  (total_len_i),
    .chunk_len_i  (chunk_len_o),
    .base_addr_o  (base_addr),
    .total_o      (total),
    .written_o    (written),
    .len_zero_o   (len_zero)
  );

  pws_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_calc (
    .base_addr_i  (base_addr),
    .total_i      (total),
    .written_i    (written),
    .chunk_addr_o (chunk_addr_o),
    .chunk_len_o  (chunk_len_o),
    .last_o       (last)
  );

  pws_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .len_zero_i    (len_zero),
    .last_i        (last),
    .chunk_ready_i (chunk_ready_i),
    .chunk_done_i  (chunk_done_i),
    .load_o        (load),
    .advance_o     (advance),
    .chunk_valid_o (chunk_valid_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  assign chunk_offset_o = written;

  // R3: a chunk never runs past the end of its page
  a_r3_no_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_valid_o |->
      ((CLEN_W+1)'(chunk_addr_o[PAGE_W-1:0]) + (CLEN_W+1)'(chunk_len_o))
        <= (CLEN_W+1)'(PAGE_BYTES));

  // R4: every issued chunk carries data
  a_r4_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_valid_o |-> chunk_len_o != '0);

  // R7: stalled request is held unchanged
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chunk_valid_o && !chunk_ready_i) |=>
      chunk_valid_o && $stable(chunk_addr_o) && $stable(chunk_len_o)
      && $stable(chunk_offset_o));

  // R8: done is a single-cycle pulse followed by idle
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: tb/page_write_splitter_tb_top.sv
module page_write_splitter_tb_top;
  localparam int AW = 6;
  localparam int LW = 7;
  localparam int PB = 8;
  localparam int CW = $clog2(PB) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] s_addr = '0;
  logic [LW-1:0] s_len = '0;
  logic          busy, c_valid, c_done, done;
  logic          c_ready = 1'b0;
  logic [AW-1:0] c_addr;
  logic [CW-1:0] c_len;
  logic [LW-1:0] c_off;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  page_write_splitter #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(PB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(s_addr),
    .total_len_i(s_len), .busy_o(busy), .chunk_valid_o(c_valid),
    .chunk_ready_i(c_ready), .chunk_addr_o(c_addr), .chunk_len_o(c_len),
    .chunk_offset_o(c_off), .chunk_done_i(c_done), .done_o(done)
  );

  assign c_done = done_drv;
  logic done_drv = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_req(input int a, input int l);
    int written = 0;
    int idx = 0;
    @(negedge clk);
    start  = 1'b1;
    s_addr = AW'(a);
    s_len  = LW'(l);
    @(negedge clk);
    start = 1'b0;
    if (l == 0) begin
      chk(done === 1'b1, "R9 done", int'(done), 1);
      chk(c_valid === 1'b0, "R9 no chunk", int'(c_valid), 0);
      @(negedge clk);
      chk(done === 1'b0, "R8 pulse", int'(done), 0);
      chk(busy === 1'b0, "R8 idle", int'(busy), 0);
      return;
    end
    while (written < l) begin
      int cur   = (a + written) % (1 << AW);
      int room  = PB - (cur % PB);
      int exp_l = (room < l - written) ? room : (l - written);
      int stall = (a + idx) % 3;
      int wt    = (l + idx) % 3;
      string rq = (idx == 0) ? "R2 first len" : "R4 len";
      chk(c_valid === 1'b1, "R6 next valid", int'(c_valid), 1);
      chk(int'(c_len) == exp_l, rq, int'(c_len), exp_l);
      chk(int'(c_addr) == cur, "R5 addr", int'(c_addr), cur);
      chk(int'(c_off) == written, "R5 offset", int'(c_off), written);
      if (written + exp_l < l)
        chk(((cur + exp_l) % PB) == 0, "R3 boundary", (cur + exp_l) % PB, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(c_valid === 1'b1 && int'(c_addr) == cur && int'(c_len) == exp_l
            && int'(c_off) == written, "R7 hold", int'(c_len), exp_l);
      end
      c_ready = 1'b1;
      @(negedge clk);
      c_ready = 1'b0;
      chk(c_valid === 1'b0, "R6 wait", int'(c_valid), 0);
      for (int w = 0; w < wt; w++) begin
        start  = 1'b1;            // R10 spurious start while busy
        s_addr = AW'(a + 3);
        s_len  = LW'(5);
        @(negedge clk);
        chk(c_valid === 1'b0 && done === 1'b0, "R6 hold off", int'(c_valid), 0);
      end
      start = 1'b0;
      done_drv = 1'b1;
      @(negedge clk);
      done_drv = 1'b0;
      written += exp_l;
      idx++;
    end
    chk(done === 1'b1, "R8 done", int'(done), 1);
    chk(c_valid === 1'b0, "R4 sum total", int'(c_valid), 0);
    @(negedge clk);
    chk(done === 1'b0, "R8 pulse", int'(done), 0);
    chk(busy === 1'b0, "R10 idle after", int'(busy), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && c_valid === 1'b0 && done === 1'b0, "R1 reset",
        int'({busy, c_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && c_valid === 1'b0 && done === 1'b0, "R1 after release",
        int'({busy, c_valid, done}), 0);
    for (int a = 0; a < (1 << AW); a++)
      for (int l = 0; l < 20; l++)
        run_req(a, l);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule